// File: doc/BRIEF.md
# Triple-Redundant SPI Flash Scrubber

This block looks after three SPI NOR flash devices that each hold the same configuration image. It switches the memories' supply on, waits a settle time, and then walks the address range one byte at a time. Each byte is fetched from all three devices in lockstep over a shared clock and data-out line. The three serial returns are sampled on separate lanes, and a bitwise two-of-three vote gives the trusted value. The vote of the raw lanes is also driven out live as a serial stream.

Any lane whose byte differs from the voted byte is flagged. The first failing address and the mask of offending devices are logged, and a saturating counter totals the bad bytes. In repair mode the single faulty device is selected alone and rewritten with the voted byte using write-enable and page-program. The block then polls that device's status register until its write-in-progress bit clears. When no two copies of a byte agree, the block raises an uncorrectable flag and leaves the memories alone. At the end of a pass every chip-select is released and the supply is switched off again.

Top module: `tmr_flash_scrubber`

## Requirements
- R1: After reset the block is idle: `busy`, `done`, `pwr_en`, `spi_sclk` and all error outputs are 0, and every bit of `spi_cs_n` is 1.
- R2: A start raises `pwr_en`. No chip-select goes low until at least `settle_len` clock cycles have passed with power on. No chip-select is ever low while `pwr_en` is 0. At the end of a pass `pwr_en` returns to 0 with all chip-selects high.
- R3: Every byte from address 0 up to `LAST_ADDR` is read in ascending order by a separate transaction with all three chip-selects low. The transaction sends opcode 0x03 and then a 24-bit address, MSB first on `spi_mosi`, and then clocks 8 data bits. SPI mode 0 is used: the clock idles low, data is sampled on the rising clock edge, and MOSI changes while the clock is low.
- R4: `vote_miso` is at every moment the two-of-three majority of the three `spi_miso` lines.
- R5: A byte is a mismatch when any device's byte differs from the bitwise-voted byte. `err_flag` is set by the first mismatch of a pass.
- R6: `err_addr` holds the address of the first mismatch of the pass. `err_mask` bit i is 1 when device i (its MISO lane `spi_miso[i]` and chip-select `spi_cs_n[i]`) differed from the vote. Both are cleared by a start.
- R7: `err_count` counts mismatched bytes in the pass and saturates at its all-ones value.
- R8: A byte for which no two devices agree sets `uncorr_flag` and causes no write to any device, even in repair mode.
- R9: With `fix_en` at 0, mismatches are reported but no device is written.
- R10: With `fix_en` at 1, a correctable mismatch is repaired on the single faulty device. The block sends a write-enable (opcode 0x06, 8 bits) and then a page-program (0x02, 24-bit address, voted byte). Only that device's chip-select is low, and the other devices see no transaction.
- R11: After a page-program the block repeatedly reads status (opcode 0x05, 8 status bits following) from the repaired device only. It resumes the scan only once status bit 0 (busy) reads 0.
- R12: `busy` is 1 from the cycle after a start until the pass ends, and `done` is then 1 until the next start. A start while busy is ignored and the pass runs exactly as long as an undisturbed one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Pulse to begin a scrub pass |
| fix_en | input | 1 | 1 = repair faulty copies, 0 = report only |
| settle_len | input | SETTLE_W | Cycles to wait after power-on before first select |
| busy | output | 1 | Pass in progress |
| done | output | 1 | Last pass finished |
| err_flag | output | 1 | At least one mismatch in the pass |
| uncorr_flag | output | 1 | A byte had no two agreeing copies |
| err_addr | output | ADDR_W | Address of the first mismatch |
| err_mask | output | 3 | Devices that disagreed at the first mismatch |
| err_count | output | CNT_W | Saturating count of mismatched bytes |
| pwr_en | output | 1 | Memory supply enable |
| spi_sclk | output | 1 | Shared SPI clock |
| spi_mosi | output | 1 | Shared SPI data to the devices |
| spi_cs_n | output | 3 | Per-device active-low chip-select |
| spi_miso | input | 3 | Per-device serial data from the devices |
| vote_miso | output | 1 | Majority of the three MISO lanes |

## Verification
The bench attacks repair targeting. A design that picks the wrong device, or selects all three, programs a healthy copy, and the per-device program counts catch it. A design that skips status polling shows too few status reads. The bench plants a byte where every copy differs; a block that treats it as fixable programs a memory and misses the uncorrectable flag. The bench also drives more bad bytes than a narrow counter holds, so a wrapping counter reads low. A second start in mid-pass must not restart the walk, and a restart shows as a longer pass. Two further monitors cover power: one catches any select before the settle time or while unpowered, and one checks the live vote output.

// File: rtl/tmr_scrub_pkg.sv
package tmr_scrub_pkg;
   localparam int NDEV = 3;

   localparam logic [7:0] OP_READ = 8'h03;
   localparam logic [7:0] OP_WREN = 8'h06;
   localparam logic [7:0] OP_PROG = 8'h02;
   localparam logic [7:0] OP_RDSR = 8'h05;

   typedef enum logic [2:0] {
      S_IDLE, S_SETTLE, S_RD, S_WREN, S_PP, S_POLL, S_OFF
   } scrub_state_t;

   function automatic logic maj3(input logic a, input logic b, input logic c);
      return (a & b) | (a & c) | (b & c);
   endfunction
endpackage

// File: rtl/tmr_byte_vote.sv
module tmr_byte_vote import tmr_scrub_pkg::*; #(
   parameter int W = 8
) (
   input  logic [W-1:0]    lane_a,
   input  logic [W-1:0]    lane_b,
   input  logic [W-1:0]    lane_c,
   output logic [W-1:0]    voted,
   output logic [NDEV-1:0] dis_mask,
   output logic            no_pair
);
   generate
      if (W < 1) begin : g_bad_w
         $error("tmr_byte_vote: W must be at least 1");
      end
      for (genvar i = 0; i < W; i++) begin : g_bit
         assign voted[i] = maj3(lane_a[i], lane_b[i], lane_c[i]);
      end
   endgenerate

   assign dis_mask = {lane_c != voted, lane_b != voted, lane_a != voted};
   assign no_pair  = (lane_a != lane_b) && (lane_a != lane_c) && (lane_b != lane_c);
endmodule

// File: rtl/scrub_spi_engine.sv
module scrub_spi_engine #(
   parameter int FRAME_W = 40,
   parameter int LANES   = 3,
   localparam int LEN_W  = $clog2(FRAME_W + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  go,
   input  logic [LEN_W-1:0]      nbits,
   input  logic [FRAME_W-1:0]    frame,
   input  logic [LANES-1:0]      miso,
   output logic                  sclk,
   output logic                  mosi,
   output logic                  busy,
   output logic                  done,
   output logic [LANES-1:0][7:0] rx
);
   logic [FRAME_W-1:0] sh;
   logic [LEN_W-1:0]   cnt;

   assign mosi = sh[FRAME_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh   <= '0;
         cnt  <= '0;
         sclk <= 1'b0;
         busy <= 1'b0;
         done <= 1'b0;
         rx   <= '0;
      end else begin
         done <= 1'b0;
         if (go && !busy) begin
            busy <= 1'b1;
            sh   <= frame;
            cnt  <= nbits;
            sclk <= 1'b0;
         end else if (busy) begin
            if (!sclk) begin
               sclk <= 1'b1;
               for (int l = 0; l < LANES; l++) rx[l] <= {rx[l][6:0], miso[l]};
            end else begin
               sclk <= 1'b0;
               sh   <= sh << 1;
               cnt  <= cnt - 1'b1;
               if (cnt == LEN_W'(1)) begin
                  busy <= 1'b0;
                  done <= 1'b1;
               end
            end
         end
      end
   end

   // mode 0: clock rests low between frames
   assert_sclk_idle_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sclk);
endmodule

// File: rtl/scrub_err_log.sv
module scrub_err_log import tmr_scrub_pkg::*; #(
   parameter int ADDR_W = 24,
   parameter int CNT_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              hit,
   input  logic              hit_unc,
   input  logic [ADDR_W-1:0] hit_addr,
   input  logic [NDEV-1:0]   hit_mask,
   output logic              flag,
   output logic              unc_flag,
   output logic [ADDR_W-1:0] first_addr,
   output logic [NDEV-1:0]   first_mask,
   output logic [CNT_W-1:0]  count
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag       <= 1'b0;
         unc_flag   <= 1'b0;
         first_addr <= '0;
         first_mask <= '0;
         count      <= '0;
      end else if (clr) begin
         flag       <= 1'b0;
         unc_flag   <= 1'b0;
         first_addr <= '0;
         first_mask <= '0;
         count      <= '0;
      end else if (hit) begin
         if (!flag) begin
            first_addr <= hit_addr;
            first_mask <= hit_mask;
         end
         flag <= 1'b1;
         if (hit_unc) unc_flag <= 1'b1;
         if (count != CNT_MAX) count <= count + 1'b1;
      end
   end

   assert_count_saturates_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (count == CNT_MAX && !clr) |=> count == CNT_MAX);
   assert_first_addr_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clr) |=> $stable(first_addr) && $stable(first_mask));
endmodule

// File: rtl/tmr_flash_scrubber.sv
module tmr_flash_scrubber import tmr_scrub_pkg::*; #(
   parameter int          ADDR_W    = 24,
   parameter int unsigned LAST_ADDR = 32'h00FF_FFFF,
   parameter int          CNT_W     = 16,
   parameter int          SETTLE_W  = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                fix_en,
   input  logic [SETTLE_W-1:0] settle_len,
   output logic                busy,
   output logic                done,
   output logic                err_flag,
   output logic                uncorr_flag,
   output logic [ADDR_W-1:0]   err_addr,
   output logic [NDEV-1:0]     err_mask,
   output logic [CNT_W-1:0]    err_count,
   output logic                pwr_en,
   output logic                spi_sclk,
   output logic                spi_mosi,
   output logic [NDEV-1:0]     spi_cs_n,
   input  logic [NDEV-1:0]     spi_miso,
   output logic                vote_miso
);
   localparam int FRAME_W = 16 + ADDR_W;
   localparam int LEN_W   = $clog2(FRAME_W + 1);
   localparam logic [ADDR_W-1:0] ADDR_END = ADDR_W'(LAST_ADDR);

   generate
      if (ADDR_W != 24) begin : g_bad_aw
         $error("tmr_flash_scrubber: command format needs ADDR_W == 24");
      end
      if (LAST_ADDR >= (64'd1 << ADDR_W)) begin : g_bad_last
         $error("tmr_flash_scrubber: LAST_ADDR beyond address space");
      end
      if (CNT_W < 1 || SETTLE_W < 1) begin : g_bad_w
         $error("tmr_flash_scrubber: counter widths must be positive");
      end
   endgenerate

   scrub_state_t            state;
   logic [ADDR_W-1:0]       addr;
   logic [SETTLE_W-1:0]     settle_cnt;
   logic                    launched, pwr_q, done_q;
   logic [NDEV-1:0]         cs_sel, fix_mask, st_busy;
   logic [7:0]              voted_q;

   logic                    eng_go, eng_busy, eng_done;
   logic [LEN_W-1:0]        eng_len;
   logic [FRAME_W-1:0]      eng_frame;
   logic [NDEV-1:0][7:0]    eng_rx;

   logic [7:0]              v_byte;
   logic [NDEV-1:0]         v_mask;
   logic                    v_unc, rd_end, mism, at_end, poll_busy;

   assign eng_go = (state inside {S_RD, S_WREN, S_PP, S_POLL}) && !launched && !eng_busy;

   always_comb begin
      eng_frame = '0;
      eng_len   = LEN_W'(8);
      unique case (state)
         S_RD:    begin eng_frame = {OP_READ, addr, 8'h00};  eng_len = LEN_W'(FRAME_W); end
         S_WREN:  begin eng_frame = {OP_WREN, {(FRAME_W-8){1'b0}}}; eng_len = LEN_W'(8); end
         S_PP:    begin eng_frame = {OP_PROG, addr, voted_q}; eng_len = LEN_W'(FRAME_W); end
         S_POLL:  begin eng_frame = {OP_RDSR, {(FRAME_W-8){1'b0}}}; eng_len = LEN_W'(16); end
         default: begin eng_frame = '0; eng_len = LEN_W'(8); end
      endcase
   end

   scrub_spi_engine #(.FRAME_W(FRAME_W), .LANES(NDEV)) u_eng (
      .clk(clk), .rst_n(rst_n), .go(eng_go), .nbits(eng_len), .frame(eng_frame),
      .miso(spi_miso), .sclk(spi_sclk), .mosi(spi_mosi), .busy(eng_busy),
      .done(eng_done), .rx(eng_rx));

   tmr_byte_vote #(.W(8)) u_vote (
      .lane_a(eng_rx[0]), .lane_b(eng_rx[1]), .lane_c(eng_rx[2]),
      .voted(v_byte), .dis_mask(v_mask), .no_pair(v_unc));

   generate
      for (genvar g = 0; g < NDEV; g++) begin : g_stat
         assign st_busy[g] = eng_rx[g][0];
      end
   endgenerate

   assign rd_end    = (state == S_RD) && eng_done;
   assign mism      = |v_mask;
   assign at_end    = (addr == ADDR_END);
   assign poll_busy = |(st_busy & fix_mask);
   assign vote_miso = maj3(spi_miso[0], spi_miso[1], spi_miso[2]);

   scrub_err_log #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_log (
      .clk(clk), .rst_n(rst_n), .clr((state == S_IDLE) && start),
      .hit(rd_end && mism), .hit_unc(v_unc), .hit_addr(addr), .hit_mask(v_mask),
      .flag(err_flag), .unc_flag(uncorr_flag), .first_addr(err_addr),
      .first_mask(err_mask), .count(err_count));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= S_IDLE;
         addr       <= '0;
         settle_cnt <= '0;
         launched   <= 1'b0;
         pwr_q      <= 1'b0;
         done_q     <= 1'b0;
         cs_sel     <= '0;
         fix_mask   <= '0;
         voted_q    <= '0;
      end else begin
         if (eng_go) begin
            launched <= 1'b1;
            cs_sel   <= (state == S_RD) ? {NDEV{1'b1}} : fix_mask;
         end
         if (eng_done) begin
            launched <= 1'b0;
            cs_sel   <= '0;
         end
         unique case (state)
            S_IDLE: if (start) begin
               pwr_q      <= 1'b1;
               done_q     <= 1'b0;
               addr       <= '0;
               settle_cnt <= settle_len;
               state      <= S_SETTLE;
            end
            S_SETTLE: if (settle_cnt == '0) state <= S_RD;
                      else settle_cnt <= settle_cnt - 1'b1;
            S_RD: if (eng_done) begin
               if (mism && fix_en && !v_unc) begin
                  fix_mask <= v_mask;
                  voted_q  <= v_byte;
                  state    <= S_WREN;
               end else if (at_end) state <= S_OFF;
               else addr <= addr + 1'b1;
            end
            S_WREN: if (eng_done) state <= S_PP;
            S_PP:   if (eng_done) state <= S_POLL;
            S_POLL: if (eng_done && !poll_busy) begin
               if (at_end) state <= S_OFF;
               else begin
                  addr  <= addr + 1'b1;
                  state <= S_RD;
               end
            end
            S_OFF: begin
               pwr_q  <= 1'b0;
               done_q <= 1'b1;
               state  <= S_IDLE;
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   assign spi_cs_n = ~cs_sel;
   assign pwr_en   = pwr_q;
   assign done     = done_q;
   assign busy     = (state != S_IDLE);

   assert_cs_unpowered_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_en |-> spi_cs_n == {NDEV{1'b1}});
   assert_fix_single_dev_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (state == S_WREN || state == S_PP || state == S_POLL) |-> $countones(fix_mask) == 1);
   assert_unc_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_end && v_unc) |=> state != S_WREN);
   assert_start_ignored_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (state inside {S_RD, S_WREN, S_PP, S_POLL} && start) |=> state != S_SETTLE);
endmodule

// File: tb/tmr_flash_scrubber_test.sv
`timescale 1ns/1ps

module flash_dev_model #(parameter int DEPTH = 16) (
   input  logic pwr,
   input  logic cs_n,
   input  logic sclk,
   input  logic mosi,
   output logic miso
);
   logic [7:0]  mem [DEPTH];
   logic [7:0]  op, din;
   logic [23:0] adr;
   logic [7:0]  stat;
   int bits, busy_left, prog_cnt, rdsr_cnt;
   logic wel;

   initial begin
      miso = 1'b0; op = '0; din = '0; adr = '0; bits = 0; wel = 1'b0;
      busy_left = 0; prog_cnt = 0; rdsr_cnt = 0;
   end

   always @(negedge cs_n) begin
      bits = 0;
      op   = '0;
   end

   always @(posedge sclk) if (!cs_n && pwr) begin
      if (bits < 8)       op  = {op[6:0], mosi};
      else if (bits < 32) adr = {adr[22:0], mosi};
      else if (bits < 40) din = {din[6:0], mosi};
      bits = bits + 1;
   end

   always @(negedge sclk) if (!cs_n && pwr) begin
      stat = {6'b0, wel, busy_left != 0};
      if (op == 8'h03 && bits >= 32 && bits < 40) miso = mem[adr % DEPTH][39 - bits];
      else if (op == 8'h05 && bits >= 8 && bits < 16) miso = stat[15 - bits];
      else miso = 1'b0;
   end

   always @(posedge cs_n) begin
      miso = 1'b0;
      if (op == 8'h06 && bits == 8) wel = 1'b1;
      if (op == 8'h02 && bits == 40 && wel && busy_left == 0) begin
         mem[adr % DEPTH] = din;
         prog_cnt  = prog_cnt + 1;
         wel       = 1'b0;
         busy_left = 2;
      end
      if (op == 8'h05 && bits == 16) begin
         rdsr_cnt = rdsr_cnt + 1;
         if (busy_left > 0) busy_left = busy_left - 1;
      end
   end
endmodule

module tmr_flash_scrubber_test;
   localparam int DEPTH  = 16;
   localparam int CNTW   = 2;
   localparam int SETTLE = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic start = 1'b0;
   logic fix_en = 1'b0;
   logic [7:0] settle_len = 8'(SETTLE);
   logic busy, done, err_flag, uncorr_flag, pwr_en, spi_sclk, spi_mosi, vote_miso;
   logic [23:0] err_addr;
   logic [2:0] err_mask, spi_cs_n, spi_miso;
   logic [CNTW-1:0] err_count;

   always #2.5 clk = ~clk;

   tmr_flash_scrubber #(.ADDR_W(24), .LAST_ADDR(DEPTH - 1), .CNT_W(CNTW), .SETTLE_W(8)) uut (
      .clk(clk), .rst_n(rst_n), .start(start), .fix_en(fix_en), .settle_len(settle_len),
      .busy(busy), .done(done), .err_flag(err_flag), .uncorr_flag(uncorr_flag),
      .err_addr(err_addr), .err_mask(err_mask), .err_count(err_count), .pwr_en(pwr_en),
      .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n), .spi_miso(spi_miso),
      .vote_miso(vote_miso));

   flash_dev_model #(.DEPTH(DEPTH)) d0 (.pwr(pwr_en), .cs_n(spi_cs_n[0]), .sclk(spi_sclk), .mosi(spi_mosi), .miso(spi_miso[0]));
   flash_dev_model #(.DEPTH(DEPTH)) d1 (.pwr(pwr_en), .cs_n(spi_cs_n[1]), .sclk(spi_sclk), .mosi(spi_mosi), .miso(spi_miso[1]));
   flash_dev_model #(.DEPTH(DEPTH)) d2 (.pwr(pwr_en), .cs_n(spi_cs_n[2]), .sclk(spi_sclk), .mosi(spi_mosi), .miso(spi_miso[2]));

   int n_chk = 0, n_bad = 0;
   int off_viol = 0, vote_viol = 0, gap = 0, last_gap = 0;
   bit seen_cs = 1'b0;

   task automatic check(input string req, input string what, input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic logic [7:0] gold(input int i);
      return 8'(i * 37 + 5);
   endfunction

   // R2 / R4 monitors at the falling clock edge
   always @(negedge clk) if (rst_n) begin
      if (!pwr_en && spi_cs_n != 3'b111) off_viol++;
      if (vote_miso !== ((spi_miso[0] & spi_miso[1]) | (spi_miso[0] & spi_miso[2]) | (spi_miso[1] & spi_miso[2])))
         vote_viol++;
      if (!pwr_en) begin
         gap = 0; seen_cs = 1'b0;
      end else if (!seen_cs) begin
         if (spi_cs_n == 3'b111) gap++;
         else begin seen_cs = 1'b1; last_gap = gap; end
      end
   end

   task automatic fill();
      for (int i = 0; i < DEPTH; i++) begin
         d0.mem[i] = gold(i); d1.mem[i] = gold(i); d2.mem[i] = gold(i);
      end
      d0.prog_cnt = 0; d1.prog_cnt = 0; d2.prog_cnt = 0;
      d0.rdsr_cnt = 0; d1.rdsr_cnt = 0; d2.rdsr_cnt = 0;
   endtask

   // runs one pass; extra_at > 0 pulses start again that many cycles in
   task automatic run_scan(input bit fix, input int extra_at, output int cycles, output int busy_gaps);
      cycles = 0; busy_gaps = 0;
      @(negedge clk);
      fix_en = fix; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!done && cycles < 20000) begin
         if (!busy) busy_gaps++;
         if (extra_at > 0 && cycles == extra_at) start = 1'b1;
         else start = 1'b0;
         @(negedge clk);
         cycles++;
      end
      start = 1'b0;
      if (cycles >= 20000) check("R12", "pass timeout", cycles, 0);
   endtask

   task automatic t_reset();
      check("R1", "busy", busy, 0);
      check("R1", "done", done, 0);
      check("R1", "pwr_en", pwr_en, 0);
      check("R1", "cs_n", spi_cs_n, 3'b111);
      check("R1", "sclk", spi_sclk, 0);
      check("R1", "err_count", err_count, 0);
   endtask

   task automatic t_clean(output int dur);
      int bg;
      fill();
      run_scan(1'b0, 0, dur, bg);
      check("R3", "clean err_flag", err_flag, 0);
      check("R3", "clean err_count", err_count, 0);
      check("R12", "done after pass", done, 1);
      check("R12", "busy low before end", bg, 0);
      check("R2", "pwr off after pass", pwr_en, 0);
      check("R2", "cs high after pass", spi_cs_n, 3'b111);
      check("R2", "settle gap ok", last_gap >= SETTLE, 1);
   endtask

   task automatic t_report();
      int c, bg;
      fill();
      d1.mem[3] = gold(3) ^ 8'h10;
      d2.mem[9] = gold(9) ^ 8'h81;
      run_scan(1'b0, 0, c, bg);
      check("R5", "err_flag", err_flag, 1);
      check("R6", "first addr", err_addr, 3);
      check("R6", "first mask", err_mask, 3'b010);
      check("R7", "count", err_count, 2);
      check("R9", "no programs", d0.prog_cnt + d1.prog_cnt + d2.prog_cnt, 0);
      check("R9", "copy left bad", d1.mem[3], gold(3) ^ 8'h10);
   endtask

   task automatic t_fix();
      int c, bg;
      fill();
      d1.mem[3] = gold(3) ^ 8'h10;
      d2.mem[9] = gold(9) ^ 8'h81;
      run_scan(1'b1, 0, c, bg);
      check("R10", "count", err_count, 2);
      check("R10", "uncorr clear", uncorr_flag, 0);
      check("R10", "d1 repaired", d1.mem[3], gold(3));
      check("R10", "d2 repaired", d2.mem[9], gold(9));
      check("R10", "d0 untouched", d0.prog_cnt, 0);
      check("R10", "d1 programs", d1.prog_cnt, 1);
      check("R10", "d2 programs", d2.prog_cnt, 1);
      check("R11", "d1 status polls", d1.rdsr_cnt, 3);
      check("R11", "d0 no polls", d0.rdsr_cnt, 0);
      run_scan(1'b0, 0, c, bg);
      check("R6", "rescan clears log", err_flag, 0);
      check("R10", "rescan clean", err_count, 0);
   endtask

   task automatic t_uncorr();
      int c, bg;
      fill();
      d0.mem[5] = gold(5) ^ 8'h01;
      d1.mem[5] = gold(5) ^ 8'h02;
      run_scan(1'b1, 0, c, bg);
      check("R8", "uncorr flag", uncorr_flag, 1);
      check("R8", "no programs", d0.prog_cnt + d1.prog_cnt + d2.prog_cnt, 0);
      check("R6", "mask", err_mask, 3'b011);
      check("R6", "addr", err_addr, 5);
   endtask

   task automatic t_saturate();
      int c, bg;
      fill();
      for (int i = 0; i < 5; i++) d0.mem[i] = gold(i) ^ 8'h40;
      run_scan(1'b0, 0, c, bg);
      check("R7", "saturated count", err_count, 3);
      check("R6", "first addr", err_addr, 0);
      check("R6", "first mask", err_mask, 3'b001);
   endtask

   task automatic t_restart(input int ref_dur);
      int c, bg;
      fill();
      run_scan(1'b0, 300, c, bg);
      check("R12", "pass length with extra start", c, ref_dur);
      check("R12", "busy held", bg, 0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL R12 watchdog: actual=expired expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      int dur;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_clean(dur);
      t_report();
      t_fix();
      t_uncorr();
      t_saturate();
      t_restart(dur);
      check("R2", "cs low while unpowered", off_viol, 0);
      check("R4", "vote stream errors", vote_viol, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule